// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

The block is a watchdog that counts on its own free-running clock. It therefore keeps counting while the main system clock is stopped during sleep. When the watchdog count runs out, the block raises a reset request if the core is awake. If the core is asleep, it raises a wake request instead and returns to the awake state. A status flag goes low on every time-out, so software can tell a watchdog-caused restart apart from a power-on start.

One 7-stage binary divider with eight taps is shared between two users. A routing bit selects its place. Routed to the watchdog, the divider sits behind the watchdog counter as a postscaler and stretches the time-out. Routed to the general timer, it divides the timer's clock source and produces a tick for the timer counter, which is outside this block.

Clear and sleep-entry strobes come from the system clock domain. The timer clock source is also an asynchronous level. Each of these passes through a two-flop synchroniser and a rising-edge detector before it acts. The enable, routing and ratio inputs are treated as quasi-static configuration.

Top module: `watchdog_ps`

## Requirements
- R1: While reset is asserted, `rst_req`, `wake_req` and `tmr_tick` are low and `to_n` is high.
- R2: With `div_route`=0, the first `rst_req` pulse after a clear appears on the 259th rising edge of `wdt_clk`, counting from the clear strobe going high. That count is 2 synchroniser stages, 1 edge-detect cycle and 256 counts. Further pulses then follow every 256 cycles. Each request is a one-cycle pulse, and a strobe held high acts only once.
- R3: With `div_route`=1 and `div_ratio`=k (000 to 111), the time-out period becomes 2^k × 256 cycles. The first request therefore appears 3 + 2^k × 256 edges after the clear strobe rises.
- R4: A clear strobe restarts both the watchdog count and, when routed to the watchdog, the divider. Any partial progress made before the clear is discarded. The routing and ratio settings are left unchanged.
- R5: A sleep-entry strobe restarts the count in the same way and puts the block into the asleep state. A time-out while asleep pulses `wake_req` instead of `rst_req` and returns the block to awake. The next time-out then pulses `rst_req`.
- R6: `to_n` goes low on the cycle of any request pulse. It is set high only by a clear strobe or by reset; a sleep strobe leaves it unchanged.
- R7: While `cfg_en` is low, the watchdog never produces a request.
- R8: With `div_route`=0, `tmr_tick` pulses exactly once for every 2^k rising edges of `tmr_src`. With `div_route`=1, `tmr_tick` stays low.
- R9: A clear strobe whose synchronised edge falls in the same cycle as the terminal count wins. No request is raised, `to_n` stays high, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wdt_clk | input | 1 | Dedicated free-running watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Watchdog enable; low keeps the watchdog idle |
| clr_req | input | 1 | Clear strobe from the system domain (rising edge acts) |
| sleep_req | input | 1 | Sleep-entry strobe from the system domain (rising edge acts) |
| tmr_src | input | 1 | General timer clock source (rising edge counts) |
| div_route | input | 1 | 1 = divider is watchdog postscaler, 0 = timer prescaler |
| div_ratio | input | 3 | Divider tap select, ratio 2^code |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_n | output | 1 | Time-out status flag, low after a watchdog time-out |
| tmr_tick | output | 1 | Divided tick toward the timer counter |

## Verification
A clear strobe and the watchdog's terminal count can land in the same `wdt_clk` cycle. The clear must then take priority over the time-out. The bench waits for a time-out pulse and counts 253 edges from it. It then raises the clear, so that the synchronised edge meets the cycle in which the count sits at its maximum. It judges the outcome by seeing no request in that cycle, `to_n` still high, and the next request arriving a full 259 edges after the strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Where the shared divider is placed.
  typedef enum logic {
    DIV_TO_TIMER = 1'b0,
    DIV_TO_WDT   = 1'b1
  } div_route_e;

  // Indices into the synchronised strobe vector.
  localparam int STB_CLR   = 0;
  localparam int STB_SLEEP = 1;
  localparam int STB_TMR   = 2;
  localparam int STB_COUNT = 3;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q, stage_d;
  logic [WIDTH-1:0]             prev_q;
  logic [WIDTH-1:0]             level;

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  assign level = stage_q[STAGES-1];
  assign rise  = level & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= level;
    end
  end

  // R2: a held level produces a single edge event
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en || restart) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign ovf = en & ~restart & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4: a restart leaves the count at zero
  a_r4_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R7: disabled watchdog keeps its count idle
  a_r7_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R2: enabled and not restarted, the count advances by one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int TAPS = 8,
  localparam int SEL_W = $clog2(TAPS),
  localparam int CW    = TAPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TAPS-1:0] tap;

  // Tap k fires on the event that completes a group of 2^k events.
  assign tap[0] = src;
  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
      assign tap[k] = src & (&cnt_q[k-1:0]);
    end
  endgenerate

  assign pulse = tap[sel] & ~clr;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (src) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4: clearing the divider empties its count
  a_r4_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R8: without a source event the divider holds
  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/watchdog_ps.sv
module watchdog_ps
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TAPS        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(TAPS)
) (
  input  logic             wdt_clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             clr_req,
  input  logic             sleep_req,
  input  logic             tmr_src,
  input  logic             div_route,
  input  logic [SEL_W-1:0] div_ratio,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_n,
  output logic             tmr_tick
);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign arst_n = rsync_q[1];

  // Strobe synchronisation.
  logic [STB_COUNT-1:0] stb_in, stb_rise;
  logic                 clr_rise, slp_rise, tmr_rise, restart;

  always_comb begin
    stb_in            = '0;
    stb_in[STB_CLR]   = clr_req;
    stb_in[STB_SLEEP] = sleep_req;
    stb_in[STB_TMR]   = tmr_src;
  end

  wdt_sync #(.WIDTH(STB_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (wdt_clk),
    .rst_n    (arst_n),
    .async_in (stb_in),
    .rise     (stb_rise)
  );

  assign clr_rise = stb_rise[STB_CLR];
  assign slp_rise = stb_rise[STB_SLEEP];
  assign tmr_rise = stb_rise[STB_TMR];
  assign restart  = clr_rise | slp_rise;

  // Watchdog count and shared divider.
  div_route_e route;
  logic       psa, wd_ovf, div_src, div_clr, div_pulse, timeout;

  assign route = div_route_e'(div_route);
  assign psa   = (route == DIV_TO_WDT);

  wdt_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (wdt_clk),
    .rst_n   (arst_n),
    .en      (cfg_en),
    .restart (restart),
    .ovf     (wd_ovf)
  );

  assign div_src = psa ? wd_ovf : tmr_rise;
  assign div_clr = psa & restart;

  wdt_divider #(.TAPS(TAPS)) u_div (
    .clk   (wdt_clk),
    .rst_n (arst_n),
    .src   (div_src),
    .clr   (div_clr),
    .sel   (div_ratio),
    .pulse (div_pulse)
  );

  assign timeout = psa ? div_pulse : wd_ovf;

  // Request, status and tick registers.
  logic asleep_q, asleep_d;
  logic rst_q, rst_d, wake_q, wake_d, to_q, to_d, tick_q, tick_d;

  always_comb begin
    asleep_d = asleep_q;
    if (timeout) begin
      asleep_d = 1'b0;
    end else if (slp_rise) begin
      asleep_d = 1'b1;
    end

    to_d = to_q;
    if (timeout) begin
      to_d = 1'b0;
    end else if (clr_rise) begin
      to_d = 1'b1;
    end

    rst_d  = timeout & ~asleep_q;
    wake_d = timeout & asleep_q;
    tick_d = ~psa & div_pulse;
  end

  always_ff @(posedge wdt_clk or negedge arst_n) begin
    if (!arst_n) begin
      asleep_q <= 1'b0;
      to_q     <= 1'b1;
      rst_q    <= 1'b0;
      wake_q   <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      asleep_q <= asleep_d;
      to_q     <= to_d;
      rst_q    <= rst_d;
      wake_q   <= wake_d;
      tick_q   <= tick_d;
    end
  end

  assign rst_req  = rst_q;
  assign wake_req = wake_q;
  assign to_n     = to_q;
  assign tmr_tick = tick_q;

  // R5: a time-out turns into exactly one kind of request
  a_r5_one_request: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    !(rst_req && wake_req));

  // R6: any request comes with the status flag low
  a_r6_flag_low: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    (rst_req || wake_req) |-> !to_n);

  // R6: the status flag only returns high after a clear
  a_r6_flag_set_by_clear: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    $rose(to_n) |-> $past(clr_rise));

  // R7: disabled watchdog raises nothing
  a_r7_off_silent: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    !cfg_en |=> !(rst_req || wake_req));

  // R8: divider routed to the watchdog gives no timer tick
  a_r8_tick_quiet: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    psa |=> !tmr_tick);

  // R9: a restart cycle never yields a request
  a_r9_clear_wins: assert property (@(posedge wdt_clk) disable iff (!arst_n)
    restart |=> !(rst_req || wake_req));

endmodule

// File: tb/watchdog_ps_test.sv
module watchdog_ps_test;

  localparam int CLK_NS = 10;
  localparam int CNT_W  = 8;
  localparam int SYNC   = 2;
  localparam int PERIOD = 1 << CNT_W;
  localparam int LAT    = SYNC + 1;

  logic       clk, rst_n, cfg_en, clr_req, sleep_req, tmr_src, div_route;
  logic [2:0] div_ratio;
  logic       rst_req, wake_req, to_n, tmr_tick;

  int checks = 0;
  int errors = 0;
  int ticks_seen = 0;

  watchdog_ps #(.CNT_W(CNT_W), .TAPS(8), .SYNC_STAGES(SYNC)) uut (
    .wdt_clk   (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .clr_req   (clr_req),
    .sleep_req (sleep_req),
    .tmr_src   (tmr_src),
    .div_route (div_route),
    .div_ratio (div_ratio),
    .rst_req   (rst_req),
    .wake_req  (wake_req),
    .to_n      (to_n),
    .tmr_tick  (tmr_tick)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) if (tmr_tick) ticks_seen++;

  function automatic int exp_timeout(input bit post, input int k);
    return LAT + (post ? (1 << k) : 1) * PERIOD;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise a strobe at a falling edge and count rising edges to the request.
  task automatic run_timeout(input bit use_sleep, input int exp_n, input bit exp_wake,
                             input bit exp_mid_to, input string req);
    int  n;
    bit  found;
    @(negedge clk);
    if (use_sleep) sleep_req = 1'b1; else clr_req = 1'b1;
    n = 0;
    found = 1'b0;
    while (!found && n < exp_n + 64) begin
      @(negedge clk);
      n++;
      if (n == 4) begin
        clr_req   = 1'b0;
        sleep_req = 1'b0;
      end
      if (n == 8) check(to_n == exp_mid_to, "R6 flag after strobe", to_n, exp_mid_to);
      if (rst_req || wake_req) found = 1'b1;
    end
    check(n == exp_n, req, n, exp_n);
    check(wake_req == exp_wake, {req, " wake"}, wake_req, exp_wake);
    check(rst_req == !exp_wake, {req, " reset"}, rst_req, !exp_wake);
    check(to_n == 1'b0, "R6 flag on time-out", to_n, 0);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rst_req || wake_req) && n < 40000);
  endtask

  task automatic tick_run(input bit post, input int k, input int m);
    int start;
    div_route = post;
    div_ratio = 3'(k);
    repeat (8) @(negedge clk);
    start = ticks_seen;
    for (int e = 0; e < (1 << k) * m; e++) begin
      tmr_src = 1'b1;
      repeat (2) @(negedge clk);
      tmr_src = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check(ticks_seen - start == (post ? 0 : m), "R8 tick count", ticks_seen - start,
          post ? 0 : m);
  endtask

  initial begin
    #(CLK_NS * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: run hung");
    summary();
    $finish;
  end

  initial begin
    int n;
    int k;
    int d;
    int pulses;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; cfg_en = 1'b1; clr_req = 1'b0; sleep_req = 1'b0;
    tmr_src = 1'b0; div_route = 1'b0; div_ratio = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    check(wake_req == 1'b0, "R1 wake_req", wake_req, 0);
    check(to_n == 1'b1, "R1 to_n", to_n, 1);
    check(tmr_tick == 1'b0, "R1 tmr_tick", tmr_tick, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 direct period, then free-running repeat
    run_timeout(1'b0, exp_timeout(1'b0, 0), 1'b0, 1'b1, "R2 first period");
    wait_req(n);
    check(n == PERIOD, "R2 repeat period", n, PERIOD);
    check(rst_req == 1'b1, "R2 repeat reset", rst_req, 1);

    // R3 postscaler directed ratios
    div_route = 1'b1;
    div_ratio = 3'd0;
    run_timeout(1'b0, exp_timeout(1'b1, 0), 1'b0, 1'b1, "R3 ratio 1");
    div_ratio = 3'd3;
    run_timeout(1'b0, exp_timeout(1'b1, 3), 1'b0, 1'b1, "R3 ratio 8");
    div_ratio = 3'd7;
    run_timeout(1'b0, exp_timeout(1'b1, 7), 1'b0, 1'b1, "R3 ratio 128");

    // R4 random ratios with partial progress discarded by the clear
    for (int i = 0; i < 5; i++) begin
      k = $urandom_range(0, 4);
      d = $urandom_range(0, 200);
      div_ratio = 3'(k);
      repeat (d) @(negedge clk);
      run_timeout(1'b0, exp_timeout(1'b1, k), 1'b0, 1'b1, "R4 restart after progress");
    end

    // R5 sleep entry: wake instead of reset, then awake again
    div_ratio = 3'd1;
    run_timeout(1'b1, exp_timeout(1'b1, 1), 1'b1, 1'b0, "R5 wake in sleep");
    wait_req(n);
    check(n == 2 * PERIOD, "R5 period after wake", n, 2 * PERIOD);
    check(rst_req == 1'b1, "R5 reset after wake", rst_req, 1);
    check(wake_req == 1'b0, "R5 no second wake", wake_req, 0);

    // R9 clear lands on the terminal-count cycle
    div_route = 1'b0;
    wait_req(n);
    repeat (PERIOD - 4) @(negedge clk);
    run_timeout(1'b0, exp_timeout(1'b0, 0), 1'b0, 1'b1, "R9 clear beats time-out");

    // R7 disabled watchdog
    cfg_en = 1'b0;
    pulses = 0;
    for (int c = 0; c < 4 * PERIOD; c++) begin
      @(negedge clk);
      if (rst_req || wake_req) pulses++;
    end
    check(pulses == 0, "R7 no request while off", pulses, 0);
    cfg_en = 1'b1;
    run_timeout(1'b0, exp_timeout(1'b0, 0), 1'b0, 1'b1, "R7 re-enabled period");

    // R8 timer prescaler and quiet tick while routed to watchdog
    tick_run(1'b0, 0, 5);
    tick_run(1'b0, 2, 3);
    tick_run(1'b0, 7, 2);
    tick_run(1'b1, 1, 4);
    for (int i = 0; i < 3; i++) begin
      tick_run(1'b0, $urandom_range(0, 5), $urandom_range(1, 4));
    end

    summary();
    $finish;
  end

endmodule